// File: doc/BRIEF.md
# Bus Response Timeout and Transmitter On-Time Supervisor

This block watches the timing of a serial command/response bus. A transmitted command word ends with a parity bit, and an upstream decoder marks the middle of that bit with a one-cycle strobe. When that strobe arrives, the block starts counting protocol clock cycles. If the decoder then marks the middle of the sync field of a responding status word before the selected limit, the measurement is cancelled. If no such mark arrives in time, a no-response flag is raised. The same measurement serves transfers between two remote terminals, where the strobe pair comes from the transmit command and from the status word of the transmitting terminal.

Four response limits can be chosen. Their nominal values are 18.5, 22.5, 50.5 and 128 µs, and the permitted bands are 17.5–19.5, 21.5–23.5, 49.5–51.5 and 127–131 µs. The protocol clock can run at 10, 12, 16 or 20 MHz. Every limit is an exact number of half microseconds, so each limit becomes an exact cycle count, taken from a table that is built when the design elaborates. A second counter checks how long the local transmitter stays on without a break. After 660.5 µs of continuous transmission it raises a fault flag and a transmit-inhibit output. Both stay asserted until reset or a host clear.

Top module: `resp_supervisor`

## Requirements
- R1: After reset is released, `no_resp_o`, `wdt_fault_o` and `tx_inhibit_o` are all low.
- R2: `tmo_sel_i` selects the response limit as 0 = 37, 1 = 45, 2 = 101, 3 = 256 half-microseconds (18.5, 22.5, 50.5, 128 µs). With no status-word strobe, `no_resp_o` rises after exactly L clock edges following the edge that sampled `mid_parity_i`, where L is the limit in cycles.
- R3: `rate_sel_i` gives the protocol clock as 0 = 10, 1 = 12, 2 = 16, 3 = 20 MHz. A limit of H half-microseconds equals H × MHz / 2 cycles at every rate.
- R4: If `mid_sync_i` is sampled k edges after `mid_parity_i` with 1 ≤ k ≤ L, the measurement ends and `no_resp_o` stays low. For k = L + 1 the flag is already set.
- R5: `no_resp_o` stays high until the next `mid_parity_i`. That strobe clears the flag and restarts the count from zero, including when it arrives during a count that is still running.
- R6: Both selects are captured when `mid_parity_i` is sampled. Changing them while a count is running has no effect on that count.
- R7: `wdt_fault_o` and `tx_inhibit_o` rise after `tx_active_i` has been sampled high on 1321 × MHz / 2 consecutive edges (660.5 µs), and not one edge sooner.
- R8: Any edge at which `tx_active_i` is sampled low restarts the on-time count from zero.
- R9: Once raised, `wdt_fault_o` and `tx_inhibit_o` stay high, even with the transmitter idle, until reset or a one-cycle `wdt_clear_i` pulse clears them.
- R10: A `mid_sync_i` strobe that arrives when no count is running has no effect on `no_resp_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Protocol clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mid_parity_i | input | 1 | One-cycle strobe at mid-parity of a command word |
| mid_sync_i | input | 1 | One-cycle strobe at mid-sync of a status word |
| tx_active_i | input | 1 | Local transmitter is driving the bus |
| tmo_sel_i | input | 2 | Response limit select |
| rate_sel_i | input | 2 | Protocol clock rate select |
| wdt_clear_i | input | 1 | Host clear of the transmitter fault |
| no_resp_o | output | 1 | No-response timeout flag |
| wdt_fault_o | output | 1 | Transmitter on-time fault |
| tx_inhibit_o | output | 1 | Transmitter inhibit |

## Verification
The assertions assume that both event strobes last one clock cycle. They also assume that `rate_sel_i` does not change while the transmitter is on, because the on-time limit follows the select as it is at each moment. The stimulus changes all inputs on falling clock edges and makes every strobe and clear exactly one cycle wide. It changes the rate only while `tx_active_i` is low. Selects change during a running response count only in the directed test for R6.

// File: rtl/resp_sup_pkg.sv
package resp_sup_pkg;

   localparam int unsigned NUM_SEL = 4;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   // half-microsecond count times clock in MHz, halved: exact for even rates
   function automatic int unsigned half_us_to_cycles(input int unsigned half_us,
                                                     input int unsigned mhz);
      return (half_us * mhz) / 2;
   endfunction

endpackage

// File: rtl/tmo_limit_rom.sv
module tmo_limit_rom
   import resp_sup_pkg::*;
#(
   parameter int unsigned RATE0_MHZ = 10,
   parameter int unsigned RATE1_MHZ = 12,
   parameter int unsigned RATE2_MHZ = 16,
   parameter int unsigned RATE3_MHZ = 20,
   parameter int unsigned TMO0_HUS  = 37,
   parameter int unsigned TMO1_HUS  = 45,
   parameter int unsigned TMO2_HUS  = 101,
   parameter int unsigned TMO3_HUS  = 256,
   parameter int unsigned WDT_HUS   = 1321,
   parameter int unsigned CW        = 14
) (
   input  logic [1:0]    tmo_sel_i,
   input  logic [1:0]    rate_sel_i,
   output logic [CW-1:0] tmo_lim_o,
   output logic [CW-1:0] wdt_lim_o
);

   localparam int unsigned RATES [NUM_SEL] = '{RATE0_MHZ, RATE1_MHZ, RATE2_MHZ, RATE3_MHZ};
   localparam int unsigned TMOS  [NUM_SEL] = '{TMO0_HUS, TMO1_HUS, TMO2_HUS, TMO3_HUS};

   logic [CW-1:0] tmo_tab [NUM_SEL*NUM_SEL];
   logic [CW-1:0] wdt_tab [NUM_SEL];

   for (genvar r = 0; r < NUM_SEL; r++) begin : g_rate
      localparam int unsigned RM = RATES[r];
      assign wdt_tab[r] = CW'(half_us_to_cycles(WDT_HUS, RM));
      for (genvar t = 0; t < NUM_SEL; t++) begin : g_tmo
         assign tmo_tab[r*NUM_SEL + t] = CW'(half_us_to_cycles(TMOS[t], RM));
      end
   end

   assign tmo_lim_o = tmo_tab[{rate_sel_i, tmo_sel_i}];
   assign wdt_lim_o = wdt_tab[rate_sel_i];

endmodule

// File: rtl/resp_timer.sv
module resp_timer #(
   parameter int unsigned CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mid_parity_i,
   input  logic          mid_sync_i,
   input  logic [CW-1:0] lim_i,
   output logic          timeout_o
);

   logic          armed;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         cnt       <= '0;
         lim_q     <= '0;
         timeout_o <= 1'b0;
      end else if (mid_parity_i) begin
         armed     <= 1'b1;
         cnt       <= '0;
         lim_q     <= lim_i;
         timeout_o <= 1'b0;
      end else if (armed) begin
         if (mid_sync_i) begin
            armed <= 1'b0;
         end else if (cnt == lim_q - 1'b1) begin
            armed     <= 1'b0;
            timeout_o <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R4
   sync_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && mid_sync_i && !mid_parity_i) |=> !timeout_o);

   // R5
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mid_parity_i |=> (!timeout_o && armed && cnt == '0));

   // R2
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt < lim_q));

   // R10
   stray_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !mid_parity_i) |=> $stable(timeout_o));

endmodule

// File: rtl/tx_watchdog.sv
module tx_watchdog #(
   parameter int unsigned CW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_active_i,
   input  logic          clear_i,
   input  logic [CW-1:0] lim_i,
   output logic          fault_o
);

   logic [CW-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt    <= '0;
         fault_o <= 1'b0;
      end else if (clear_i) begin
         wcnt    <= '0;
         fault_o <= 1'b0;
      end else if (!tx_active_i) begin
         wcnt <= '0;
      end else if (wcnt == lim_i - 1'b1) begin
         fault_o <= 1'b1;
      end else begin
         wcnt <= wcnt + 1'b1;
      end
   end

   // R9
   fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !clear_i) |=> fault_o);

   // R9
   fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !fault_o);

   // R7
   trip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(tx_active_i));

   // R8
   idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active_i |=> (wcnt == '0));

endmodule

// File: rtl/resp_supervisor.sv
module resp_supervisor
   import resp_sup_pkg::*;
#(
   parameter int unsigned RATE0_MHZ = 10,
   parameter int unsigned RATE1_MHZ = 12,
   parameter int unsigned RATE2_MHZ = 16,
   parameter int unsigned RATE3_MHZ = 20,
   parameter int unsigned TMO0_HUS  = 37,
   parameter int unsigned TMO1_HUS  = 45,
   parameter int unsigned TMO2_HUS  = 101,
   parameter int unsigned TMO3_HUS  = 256,
   parameter int unsigned WDT_HUS   = 1321
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mid_parity_i,
   input  logic       mid_sync_i,
   input  logic       tx_active_i,
   input  logic [1:0] tmo_sel_i,
   input  logic [1:0] rate_sel_i,
   input  logic       wdt_clear_i,
   output logic       no_resp_o,
   output logic       wdt_fault_o,
   output logic       tx_inhibit_o
);

   localparam int unsigned MAX_MHZ = max4(RATE0_MHZ, RATE1_MHZ, RATE2_MHZ, RATE3_MHZ);
   localparam int unsigned MAX_HUS = max4(TMO0_HUS, TMO1_HUS, TMO2_HUS, WDT_HUS);
   localparam int unsigned MAX_CYC = half_us_to_cycles(max4(MAX_HUS, TMO3_HUS, 1, 1), MAX_MHZ);
   localparam int unsigned CW      = $clog2(MAX_CYC + 1);

   // elaboration checks on the parameter set
   if ((RATE0_MHZ % 2) != 0 || (RATE1_MHZ % 2) != 0 ||
       (RATE2_MHZ % 2) != 0 || (RATE3_MHZ % 2) != 0) begin : g_bad_rate
      $error("clock rates must be even MHz values for exact half-microsecond limits");
   end
   if (TMO0_HUS == 0 || TMO1_HUS == 0 || TMO2_HUS == 0 ||
       TMO3_HUS == 0 || WDT_HUS == 0) begin : g_bad_lim
      $error("all limits must be non-zero");
   end
   if (CW > 24) begin : g_bad_cw
      $error("limit counter width out of range");
   end

   logic [CW-1:0] tmo_lim;
   logic [CW-1:0] wdt_lim;
   logic          fault;

   tmo_limit_rom #(
      .RATE0_MHZ(RATE0_MHZ), .RATE1_MHZ(RATE1_MHZ),
      .RATE2_MHZ(RATE2_MHZ), .RATE3_MHZ(RATE3_MHZ),
      .TMO0_HUS(TMO0_HUS), .TMO1_HUS(TMO1_HUS),
      .TMO2_HUS(TMO2_HUS), .TMO3_HUS(TMO3_HUS),
      .WDT_HUS(WDT_HUS), .CW(CW)
   ) u_rom (
      .tmo_sel_i (tmo_sel_i),
      .rate_sel_i(rate_sel_i),
      .tmo_lim_o (tmo_lim),
      .wdt_lim_o (wdt_lim)
   );

   resp_timer #(.CW(CW)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mid_parity_i(mid_parity_i),
      .mid_sync_i  (mid_sync_i),
      .lim_i       (tmo_lim),
      .timeout_o   (no_resp_o)
   );

   tx_watchdog #(.CW(CW)) u_wdt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_active_i(tx_active_i),
      .clear_i    (wdt_clear_i),
      .lim_i      (wdt_lim),
      .fault_o    (fault)
   );

   assign wdt_fault_o  = fault;
   assign tx_inhibit_o = fault;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!no_resp_o && !wdt_fault_o && !tx_inhibit_o));

endmodule

// File: tb/resp_supervisor_test.sv
module resp_supervisor_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mp = 1'b0, ms = 1'b0, tx = 1'b0, clr = 1'b0;
   logic [1:0] tsel = 2'd0, rsel = 2'd0;
   logic       no_resp, fault, inhibit;

   int errs = 0;
   int checks = 0;

   always #2 clk = ~clk;

   resp_supervisor uut (
      .clk(clk), .rst_n(rst_n), .mid_parity_i(mp), .mid_sync_i(ms),
      .tx_active_i(tx), .tmo_sel_i(tsel), .rate_sel_i(rsel), .wdt_clear_i(clr),
      .no_resp_o(no_resp), .wdt_fault_o(fault), .tx_inhibit_o(inhibit)
   );

   function automatic int mhz(input int r);
      case (r)
         0: return 10;
         1: return 12;
         2: return 16;
         default: return 20;
      endcase
   endfunction

   function automatic int exp_tmo(input int t, input int r);
      int hus;
      case (t)
         0: hus = 37;
         1: hus = 45;
         2: hus = 101;
         default: hus = 256;
      endcase
      return hus * mhz(r) / 2;
   endfunction

   function automatic int exp_wdt(input int r);
      return 1321 * mhz(r) / 2;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // starts at a falling edge; k = 0 means no status word
   task automatic resp_trial(input int t, input int r, input int k, input string req);
      int lim;
      lim = exp_tmo(t, r);
      tsel = 2'(t); rsel = 2'(r); mp = 1'b1;
      @(negedge clk); mp = 1'b0;
      if (k > 0) begin
         repeat (k - 1) @(negedge clk);
         ms = 1'b1;
         @(negedge clk); ms = 1'b0;
         check(req, int'(no_resp), (k > lim) ? 1 : 0);
      end else begin
         repeat (lim - 1) @(negedge clk);
         check(req, int'(no_resp), 0);
         @(negedge clk);
         check(req, int'(no_resp), 1);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1", int'(no_resp), 0);
      check("R1", int'(fault), 0);
      check("R1", int'(inhibit), 0);

      // R10 stray sync with nothing armed
      ms = 1'b1; @(negedge clk); ms = 1'b0; @(negedge clk);
      check("R10", int'(no_resp), 0);

      // R2 / R3 every limit at every rate, no response
      for (int r = 0; r < 4; r++)
         for (int t = 0; t < 4; t++)
            resp_trial(t, r, 0, (r == 0) ? "R2" : "R3");

      // R10 stray sync after timeout keeps the flag
      ms = 1'b1; @(negedge clk); ms = 1'b0; @(negedge clk);
      check("R10", int'(no_resp), 1);

      // R5 next mid-parity clears the flag
      mp = 1'b1; @(negedge clk); mp = 1'b0;
      check("R5", int'(no_resp), 0);
      ms = 1'b1; @(negedge clk); ms = 1'b0;

      // R4 boundaries
      resp_trial(0, 0, exp_tmo(0, 0), "R4");
      resp_trial(0, 0, exp_tmo(0, 0) + 1, "R4");
      resp_trial(1, 3, 1, "R4");
      resp_trial(2, 1, exp_tmo(2, 1), "R4");

      // R5 restart mid-count
      tsel = 2'd0; rsel = 2'd0; mp = 1'b1; @(negedge clk); mp = 1'b0;
      repeat (100) @(negedge clk);
      resp_trial(0, 0, 0, "R5");

      // R6 selects captured at mid-parity
      tsel = 2'd3; rsel = 2'd0; mp = 1'b1; @(negedge clk); mp = 1'b0;
      tsel = 2'd0; rsel = 2'd3;
      repeat (299) @(negedge clk);
      ms = 1'b1; @(negedge clk); ms = 1'b0;
      check("R6", int'(no_resp), 0);
      tsel = 2'd0; rsel = 2'd0; mp = 1'b1; @(negedge clk); mp = 1'b0;
      tsel = 2'd3; rsel = 2'd2;
      repeat (exp_tmo(0, 0)) @(negedge clk);
      check("R6", int'(no_resp), 1);

      // random response trials
      for (int i = 0; i < 16; i++) begin
         int t, r, k;
         t = int'($urandom_range(3));
         r = int'($urandom_range(3));
         k = 1 + int'($urandom_range(exp_tmo(t, r) + 2));
         resp_trial(t, r, k, "R4");
      end

      // R7 trip boundary at 20 MHz
      rsel = 2'd3; tx = 1'b1;
      repeat (exp_wdt(3) - 1) @(negedge clk);
      check("R7", int'(fault), 0);
      @(negedge clk);
      check("R7", int'(fault), 1);
      check("R7", int'(inhibit), 1);
      tx = 1'b0;
      repeat (20) @(negedge clk);
      // R9 sticky while idle
      check("R9", int'(fault), 1);
      check("R9", int'(inhibit), 1);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      check("R9", int'(fault), 0);
      check("R9", int'(inhibit), 0);

      // R8 a one-cycle gap restarts the count (12 MHz)
      rsel = 2'd1; tx = 1'b1;
      repeat (exp_wdt(1) - 1) @(negedge clk);
      tx = 1'b0; @(negedge clk); tx = 1'b1;
      repeat (exp_wdt(1) - 1) @(negedge clk);
      check("R8", int'(fault), 0);
      @(negedge clk);
      check("R8", int'(fault), 1);
      tx = 1'b0;
      clr = 1'b1; @(negedge clk); clr = 1'b0;

      // R7 random rate, trip exactly at limit
      for (int i = 0; i < 2; i++) begin
         int r;
         r = (i == 0) ? 0 : int'($urandom_range(3));
         rsel = 2'(r); tx = 1'b1;
         repeat (exp_wdt(r) - 1) @(negedge clk);
         check("R7", int'(fault), 0);
         @(negedge clk);
         check("R7", int'(fault), 1);
         tx = 1'b0;
         clr = 1'b1; @(negedge clk); clr = 1'b0;
         check("R9", int'(fault), 0);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule